// File: doc/BRIEF.md
# Two-Stage Converter Calibration Datapath

This block sits between a converter's decimation filter and its output data register. Each filtered result goes through a shared correction and then a per-channel correction. The shared correction removes a global zero-scale offset and applies a global gain. The per-channel correction removes a channel offset and applies a channel gain, taken from one of eight coefficient pairs chosen by the channel code that arrives with the result. An optional saturation step follows, and the corrected word is then latched into the data register. The scaling depends on two things: the input span, since the narrowest span doubles the weight of every offset code, and the polarity, since bipolar and unipolar use different shift amounts and bipolar re-centres on mid-scale.

All eighteen coefficients are 24 bits wide and sit in a small register file on a plain address/data bus. Reads are allowed at any time. A write lands only when the converter mode field reports idle. In any other mode the write is discarded without any sign, so a result that is being processed never sees a coefficient change partway through.

Top module: `calib_chain`

## Requirements
- R1: Unipolar result: out = floor((floor((res - k*(SO-0x800000)) * SG / 2^21) - k*(CO-0x800000)) * CG / 2^21). SO and SG are the shared offset and gain, CO and CG are the pair of the selected channel, and k = 1.
- R2: Bipolar result: the shared stage becomes floor((res - k*(SO-0x800000)) * SG / 2^22) + 0x800000, and the channel stage is the same as in R1.
- R3: When `resNarrow` is 1, k = 2 for both offsets. Otherwise k = 1.
- R4: After reset, all eighteen coefficient registers read 0x800000. This is zero offset in offset-binary coding and a gain code of 0x800000.
- R5: Address map: 0 is the shared offset and 1 is the shared gain. Channel c (0 to 7) uses 2+2c for its offset and 3+2c for its gain, and `resChan` selects c. Addresses 18 to 31 read 0 and ignore writes.
- R6: A write changes a register only when `convMode` is 3'b000. With any other mode value the register keeps its contents.
- R7: `regRdData` shows the register at `regAddr` combinationally, in every mode.
- R8: With `resClamp` = 1, negative results give 0x000000 and results above 0xFFFFFF give 0xFFFFFF.
- R9: With `resClamp` = 0, the low 24 bits of the two's-complement result are output.
- R10: A result sampled with `resValid` at clock edge n produces a one-cycle `dataRdy` pulse after edge n+2, with `dataOut` updated at that same edge. `dataOut` holds between pulses, and back-to-back results are accepted on every cycle.
- R11: Each division by a power of two rounds toward negative infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convMode | input | 3 | Converter mode; 3'b000 is idle |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address for read and write |
| regWrData | input | 24 | Write data |
| regRdData | output | 24 | Read data for regAddr |
| resValid | input | 1 | Filter result valid |
| resData | input | 24 | Raw filter result, unsigned |
| resChan | input | 3 | Channel code selecting coefficient pair |
| resBipolar | input | 1 | 1 = bipolar span |
| resNarrow | input | 1 | 1 = narrowest span (offset weight 2) |
| resClamp | input | 1 | 1 = saturate output |
| dataRdy | output | 1 | One-cycle pulse, new data latched |
| dataOut | output | 24 | Data register |

## Verification
A corrupted coefficient, a wrong channel index or a dropped pipeline stage appears at `dataOut` on the first result that uses it, two edges after that result is sampled. A reference model checks the output word and `dataRdy` on every cycle, so the error is caught on that cycle. A write that slips past the mode guard appears at once on `regRdData` when that address is read back, and again in every later result that uses that register. A rounding-direction error appears only for negative intermediate values, so those are driven on purpose.

// File: rtl/calib_pkg.sv
package calib_pkg;
  typedef struct packed {
    logic capA;   // latch shared-stage result
    logic capB;   // latch final result into data register
    logic wrEn;   // qualified coefficient write
  } calStrobe_t;

  localparam logic [2:0] IDLE_MODE = 3'b000;
endpackage

// File: rtl/calib_ctrl.sv
module calib_ctrl
  import calib_pkg::*;
#(
  parameter int NREG = 18,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          resValid,
  input  logic          regWr,
  input  logic [AW-1:0] regAddr,
  input  logic [2:0]    convMode,
  output calStrobe_t    strobe,
  output logic          dataRdy
);
  logic vldA;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldA    <= 1'b0;
      dataRdy <= 1'b0;
    end else begin
      vldA    <= resValid;
      dataRdy <= vldA;
    end
  end

  always_comb begin
    strobe.capA = resValid;
    strobe.capB = vldA;
    strobe.wrEn = regWr && (convMode == IDLE_MODE) && (32'(regAddr) < NREG);
  end
endmodule

// File: rtl/calib_dp.sv
module calib_dp
  import calib_pkg::*;
#(
  parameter int DW  = 24,
  parameter int NCH = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  calStrobe_t               strobe,
  input  logic [$clog2(2*(NCH+1))-1:0] regAddr,
  input  logic [DW-1:0]            regWrData,
  output logic [DW-1:0]            regRdData,
  input  logic [DW-1:0]            resData,
  input  logic [$clog2(NCH)-1:0]   resChan,
  input  logic                     resBipolar,
  input  logic                     resNarrow,
  input  logic                     resClamp,
  output logic [DW-1:0]            dataOut
);
  localparam int AW     = $clog2(2*(NCH+1));
  localparam int IW     = AW - 1;
  localparam int CW     = $clog2(NCH);
  localparam int NREG   = 2*(NCH+1);
  localparam int WW     = 2*DW + 16;
  localparam int SH_UNI = DW - 3;
  localparam int SH_BIP = DW - 2;
  localparam logic signed [WW-1:0] MidW = {{(WW-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};
  localparam logic signed [WW-1:0] MaxW = {{(WW-DW){1'b0}}, {DW{1'b1}}};

  function automatic logic signed [WW-1:0] zext(input logic [DW-1:0] v);
    return $signed({{(WW-DW){1'b0}}, v});
  endfunction

  function automatic logic signed [WW-1:0] ofsAdj(input logic [DW-1:0] code, input logic nar);
    logic signed [WW-1:0] v;
    v = zext(code) - MidW;
    return nar ? (v <<< 1) : v;
  endfunction

  // entry 0 = shared pair, entry 1+c = channel c
  logic [DW-1:0] ofsReg  [NCH+1];
  logic [DW-1:0] gainReg [NCH+1];
  logic [IW-1:0] wIdx;
  assign wIdx = regAddr[AW-1:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i <= NCH; i++) begin
        ofsReg[i]  <= MidW[DW-1:0];
        gainReg[i] <= MidW[DW-1:0];
      end
    end else if (strobe.wrEn) begin
      if (regAddr[0]) gainReg[wIdx] <= regWrData;
      else            ofsReg[wIdx]  <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    if (32'(regAddr) < NREG)
      regRdData = regAddr[0] ? gainReg[wIdx] : ofsReg[wIdx];
  end

  // shared stage
  logic [IW-1:0]        chIdx;
  logic signed [WW-1:0] prodA, stANext;
  assign chIdx   = IW'(resChan) + IW'(1);
  assign prodA   = (zext(resData) - ofsAdj(ofsReg[0], resNarrow)) * zext(gainReg[0]);
  assign stANext = resBipolar ? ((prodA >>> SH_BIP) + MidW) : (prodA >>> SH_UNI);

  logic signed [WW-1:0] stAq, chOfsQ;
  logic [DW-1:0]        chGainQ;
  logic                 clampQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stAq    <= '0;
      chOfsQ  <= '0;
      chGainQ <= '0;
      clampQ  <= 1'b0;
    end else if (strobe.capA) begin
      stAq    <= stANext;
      chOfsQ  <= ofsAdj(ofsReg[chIdx], resNarrow);
      chGainQ <= gainReg[chIdx];
      clampQ  <= resClamp;
    end
  end

  // per-channel stage and saturation
  logic signed [WW-1:0] prodB, stB;
  logic [DW-1:0]        finalVal;
  assign prodB = (stAq - chOfsQ) * zext(chGainQ);
  assign stB   = prodB >>> SH_UNI;

  always_comb begin
    finalVal = stB[DW-1:0];
    if (clampQ) begin
      if (stB < 0)         finalVal = '0;
      else if (stB > MaxW) finalVal = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            dataOut <= '0;
    else if (strobe.capB) dataOut <= finalVal;
  end
endmodule

// File: rtl/calib_chain.sv
module calib_chain
  import calib_pkg::*;
#(
  parameter int DW  = 24,
  parameter int NCH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [2:0]                   convMode,
  input  logic                         regWr,
  input  logic [$clog2(2*(NCH+1))-1:0] regAddr,
  input  logic [DW-1:0]                regWrData,
  output logic [DW-1:0]                regRdData,
  input  logic                         resValid,
  input  logic [DW-1:0]                resData,
  input  logic [$clog2(NCH)-1:0]       resChan,
  input  logic                         resBipolar,
  input  logic                         resNarrow,
  input  logic                         resClamp,
  output logic                         dataRdy,
  output logic [DW-1:0]                dataOut
);
  localparam int AW   = $clog2(2*(NCH+1));
  localparam int NREG = 2*(NCH+1);

  calStrobe_t strobe;

  calib_ctrl #(.NREG(NREG), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .resValid(resValid), .regWr(regWr),
    .regAddr(regAddr), .convMode(convMode), .strobe(strobe), .dataRdy(dataRdy)
  );

  calib_dp #(.DW(DW), .NCH(NCH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .resData(resData),
    .resChan(resChan), .resBipolar(resBipolar), .resNarrow(resNarrow),
    .resClamp(resClamp), .dataOut(dataOut)
  );
endmodule

// File: rtl/calib_chain_chk.sv
module calib_chain_chk #(
  parameter int DW   = 24,
  parameter int AW   = 5,
  parameter int NREG = 18
) (
  input logic          clk,
  input logic          rstN,
  input logic [2:0]    convMode,
  input logic          regWr,
  input logic [AW-1:0] regAddr,
  input logic [DW-1:0] regWrData,
  input logic [DW-1:0] regRdData,
  input logic          resValid,
  input logic          dataRdy,
  input logic [DW-1:0] dataOut
);
  // R10: pulse two edges after an accepted result
  p_rdy_after_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> ##1 dataRdy);
  p_rdy_has_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    dataRdy |-> $past(resValid, 2));
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !dataRdy |-> $stable(dataOut));
  // R6: non-idle write leaves the register unchanged
  p_busy_write_dropped_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && convMode != 3'b000) ##1 $stable(regAddr) |-> regRdData == $past(regRdData));
  // R7 / R5: idle write is visible on the next read of that address
  p_idle_write_lands_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && convMode == 3'b000 && 32'(regAddr) < NREG) ##1 $stable(regAddr)
      |-> regRdData == $past(regWrData));
  // R5: unmapped addresses read zero
  p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (32'(regAddr) >= NREG) |-> regRdData == '0);
endmodule

bind calib_chain calib_chain_chk #(.DW(DW), .AW($clog2(2*(NCH+1))), .NREG(2*(NCH+1))) u_chk (.*);

// File: tb/calib_chain_bench.sv
`timescale 1ns/1ps
module calib_chain_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  convMode = 3'b000;
  logic        regWr = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [23:0] regWrData = '0;
  logic [23:0] regRdData;
  logic        resValid = 1'b0;
  logic [23:0] resData = '0;
  logic [2:0]  resChan = '0;
  logic        resBipolar = 1'b0, resNarrow = 1'b0, resClamp = 1'b0;
  logic        dataRdy;
  logic [23:0] dataOut;

  int    total = 0, bad = 0;
  bit    finished = 0;
  string curReq = "R10";

  always #2.5 clk = ~clk;

  calib_chain u_calib_chain (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  longint      mreg [18];
  logic        mRdyA, mRdyB;
  logic [23:0] mValA, mOut;

  function automatic logic [23:0] refCalc(longint res, bit bip, bit nar, bit clp, longint oA,
                                          longint gA, longint oC, longint gC);
    longint k, t;
    k = nar ? 2 : 1;
    t = (res - k * (oA - 64'sd8388608)) * gA;
    t = bip ? ((t >>> 22) + 64'sd8388608) : (t >>> 21);
    t = (t - k * (oC - 64'sd8388608)) * gC;
    t = t >>> 21;
    if (clp) begin
      if (t < 0) return 24'h000000;
      if (t > 64'sd16777215) return 24'hFFFFFF;
    end
    return t[23:0];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 18; i++) mreg[i] <= 64'h800000;
      mRdyA <= 0; mRdyB <= 0; mValA <= 0; mOut <= 0;
    end else begin
      if (resValid)
        mValA <= refCalc(longint'(resData), resBipolar, resNarrow, resClamp, mreg[0], mreg[1],
                         mreg[2 + 2*resChan], mreg[3 + 2*resChan]);
      mRdyA <= resValid;
      mRdyB <= mRdyA;
      if (mRdyA) mOut <= mValA;
      if (regWr && convMode == 3'b000 && regAddr < 5'd18) mreg[regAddr] <= longint'(regWrData);
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(dataRdy == mRdyB, "R10 dataRdy", longint'(dataRdy), longint'(mRdyB));
      chk(dataOut == mOut, curReq, longint'(dataOut), longint'(mOut));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [23:0] d, input logic [2:0] mode);
    @(negedge clk);
    regWr = 1; regAddr = a; regWrData = d; convMode = mode;
    @(negedge clk);
    regWr = 0; convMode = 3'b000;
  endtask

  task automatic rdChk(input logic [4:0] a, input logic [23:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(regRdData == exp, req, longint'(regRdData), longint'(exp));
  endtask

  task automatic push(input logic [23:0] r, input logic [2:0] ch, input bit bip, input bit nar,
                      input bit clp, input string req);
    curReq = req;
    @(negedge clk);
    resValid = 1; resData = r; resChan = ch; resBipolar = bip; resNarrow = nar; resClamp = clp;
    @(negedge clk);
    resValid = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // reset state
    chk(dataRdy == 0, "R10 reset rdy", longint'(dataRdy), 0);
    chk(dataOut == 0, "R10 reset out", longint'(dataOut), 0);
    rstN = 1;
    for (int a = 0; a < 18; a++) rdChk(5'(a), 24'h800000, "R4 reset value");
    rdChk(5'd18, 24'h0, "R5 unmapped read");
    rdChk(5'd31, 24'h0, "R5 unmapped read");

    push(24'd100, 3'd0, 0, 0, 0, "R1 default unipolar");

    // program coefficients while idle
    wr(5'd0, 24'h800000 - 24'd50, 3'b000);
    wr(5'd1, 24'h600000, 3'b000);
    wr(5'd8, 24'h80000A, 3'b000);
    wr(5'd9, 24'h300000, 3'b000);
    rdChk(5'd9, 24'h300000, "R5 channel 3 gain address");
    push(24'd1000, 3'd3, 0, 0, 0, "R1 unipolar channel 3");
    push(24'd1000, 3'd3, 1, 0, 0, "R2 bipolar channel 3");
    push(24'd1000, 3'd3, 0, 1, 0, "R3 narrow unipolar");
    push(24'd1000, 3'd3, 1, 1, 0, "R3 narrow bipolar");
    push(24'd1000, 3'd0, 0, 0, 0, "R5 channel 0 untouched");

    // writes while busy are dropped; reads work in any mode
    wr(5'd9, 24'h123456, 3'b001);
    convMode = 3'b001;
    rdChk(5'd9, 24'h300000, "R6 busy write dropped");
    convMode = 3'b100;
    rdChk(5'd0, 24'h800000 - 24'd50, "R7 read while busy");
    convMode = 3'b000;
    wr(5'd0, 24'h000001, 3'b100);
    rdChk(5'd0, 24'h800000 - 24'd50, "R6 busy write dropped");
    wr(5'd20, 24'hABCDEF, 3'b000);
    rdChk(5'd20, 24'h0, "R5 unmapped write ignored");
    push(24'd1000, 3'd3, 0, 0, 0, "R6 coefficients intact");

    // saturation
    push(24'hFFFFFF, 3'd3, 1, 0, 1, "R8 clamp high");
    push(24'hFFFFFF, 3'd3, 1, 0, 0, "R9 wrap high");
    wr(5'd0, 24'h800000 + 24'd5000, 3'b000);
    push(24'd0, 3'd3, 0, 0, 1, "R8 clamp low");
    push(24'd0, 3'd3, 0, 0, 0, "R9 wrap low");

    // floor rounding on a negative fraction
    wr(5'd0, 24'h800001, 3'b000);
    wr(5'd1, 24'h000001, 3'b000);
    wr(5'd12, 24'h800000, 3'b000);
    wr(5'd13, 24'h200000, 3'b000);
    push(24'd0, 3'd5, 0, 0, 0, "R11 floor gives FFFFFF");
    push(24'd0, 3'd5, 0, 0, 1, "R11 floor clamps to 0");
    push(24'd0, 3'd5, 1, 0, 0, "R11 bipolar floor");

    // back-to-back results, one per cycle
    wr(5'd1, 24'h800000, 3'b000);
    curReq = "R10 back-to-back";
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      resValid = 1; resData = 24'(1000 * (i + 1)); resChan = 3'(i);
      resBipolar = i[0]; resNarrow = i[1]; resClamp = 0;
      @(negedge clk);
    end
    resValid = 0;
    repeat (5) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule